// File: doc/BRIEF.md
# Time-Slot Gating Sequencer with Retune

This block produces a one-bit gate stream, one bit per clock, grouped into frames of `N_SLOTS` clock periods. While a slot is selected, the gate is high in exactly one bit of each frame: the bit whose position matches that slot. The gate is low everywhere else. A frame with no selected slot has every bit low and is called a null frame. A frame-start strobe marks the first bit of every frame. A current-slot output reports which pattern is on the line, with zero meaning a null frame.

A retune request carries a destination slot. The controller latches it and changes the pattern only at a frame boundary. For the decision, the slots and one null position are placed on a ring of `N_SLOTS+1` positions. The controller measures the distance around this ring in each direction:

- Applying the new pattern at the next boundary costs the distance `(i - j) mod (N_SLOTS+1)`.
- Emitting one null frame first costs the distance `(j - i) mod (N_SLOTS+1)`.

The controller takes whichever path is shorter. This keeps the worst-case retune latency near half a frame.

Top module: `slot_gate_seq`

## Requirements
- R1: A frame lasts exactly `N_SLOTS` cycles, and `frame_start` is high on the first cycle of each frame and low on the other cycles.
- R2: In a frame whose `cur_slot` is s (1..N_SLOTS), `gate` is high only in the cycle at offset s-1 from the frame start. In a frame whose `cur_slot` is 0 (a null frame), `gate` stays low for all N_SLOTS cycles.
- R3: After reset, the block emits null frames with `cur_slot` = 0 and `busy` low. The first accepted request is applied at the next frame boundary, with no null frame inserted.
- R4: Take the currently selected slot as i (i not 0) and the destination as j. Define d_imm = (i-j) mod (N_SLOTS+1) and d_null = (j-i) mod (N_SLOTS+1). One null frame is emitted before the new pattern only when d_null < d_imm. When the two distances are equal, the new pattern is applied immediately.
- R5: `gate` patterns and `cur_slot` change only on the first cycle of a frame. An accepted request is applied at the first frame boundary after the cycle in which it was latched.
- R6: `busy` rises in the cycle after a request is accepted. It stays high through any inserted null frame and falls in the first cycle of the new pattern.
- R7: A request whose destination equals the currently selected slot is ignored. `busy` stays low and the pattern does not change.
- R8: A request whose slot value is 0 or greater than N_SLOTS is ignored. `busy` stays low and the pattern does not change.
- R9: A request that arrives while `busy` is high is ignored. The earlier request completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Retune request strobe |
| req_slot | input | SLOT_W | Destination slot, valid range 1..N_SLOTS |
| gate | output | 1 | Gate bit for the current cycle |
| frame_start | output | 1 | High on the first bit of every frame |
| cur_slot | output | SLOT_W | Slot of the frame on the line, 0 for a null frame |
| busy | output | 1 | A latched request is waiting to take effect |

## Verification
With seven slots the ring has eight positions, so moves fall into three kinds: immediate-shorter (2 to 7), null-shorter (7 to 2 and 2 to 5), and exact ties (5 to 1). Comparing the frames captured after each request tells apart a wrong direction choice, a reversed modulus and a tie that resolves the wrong way. The first request out of reset checks that leaving the null state never adds an extra frame. Same-slot, out-of-range and while-busy requests are each followed by captured frames to show that they leave the line untouched.

// File: rtl/slot_gate_seq.sv
module slot_gate_seq #(
  parameter int N_SLOTS = 7,
  localparam int SLOT_W = $clog2(N_SLOTS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SLOT_W-1:0] req_slot,
  output logic              gate,
  output logic              frame_start,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              busy
);

  localparam logic [SLOT_W:0]   RING    = (SLOT_W+1)'(N_SLOTS + 1);
  localparam logic [SLOT_W-1:0] LAST    = SLOT_W'(N_SLOTS - 1);
  localparam logic [SLOT_W:0]   MAX_IDX = (SLOT_W+1)'(N_SLOTS);

  logic [SLOT_W-1:0] pos;
  logic [SLOT_W-1:0] active_slot;
  logic [SLOT_W-1:0] sel_slot;
  logic [SLOT_W-1:0] dest_slot;
  logic              pend;
  logic              pend_null;

  logic [SLOT_W:0] d_imm, d_null;
  logic            in_range, accept, want_null, boundary;

  assign boundary    = (pos == LAST);
  assign frame_start = (pos == '0);
  assign gate        = (active_slot != '0) && (pos == active_slot - SLOT_W'(1));
  assign cur_slot    = active_slot;
  assign busy        = pend;

  assign in_range = (req_slot != '0) && ({1'b0, req_slot} <= MAX_IDX);
  assign accept   = req_valid && !pend && in_range && (req_slot != sel_slot);

  always_comb begin
    if (sel_slot >= req_slot)
      d_imm = {1'b0, sel_slot} - {1'b0, req_slot};
    else
      d_imm = {1'b0, sel_slot} + RING - {1'b0, req_slot};
    d_null = RING - d_imm;
  end

  assign want_null = (sel_slot != '0) && (d_null < d_imm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else if (boundary) pos <= '0;
    else pos <= pos + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_slot <= '0;
      sel_slot    <= '0;
      dest_slot   <= '0;
      pend        <= 1'b0;
      pend_null   <= 1'b0;
    end else if (pend && boundary) begin
      if (pend_null) begin
        active_slot <= '0;
        pend_null   <= 1'b0;
      end else begin
        active_slot <= dest_slot;
        sel_slot    <= dest_slot;
        pend        <= 1'b0;
      end
    end else if (accept) begin
      dest_slot <= req_slot;
      pend      <= 1'b1;
      pend_null <= want_null;
    end
  end

  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (N_SLOTS > 1 && frame_start) |=> !frame_start);

  p_gate_needs_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (cur_slot != '0));

  p_change_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_slot) |-> frame_start);

  p_busy_falls_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (frame_start && cur_slot != '0));

  p_bad_index_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && (req_slot == '0 || {1'b0, req_slot} > MAX_IDX)) |=> !busy);

  p_busy_dest_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dest_slot));

endmodule

// File: tb/slot_gate_seq_tb.sv
module slot_gate_seq_tb_top;
  localparam int N = 7;
  localparam int SW = $clog2(N + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [SW-1:0] req_slot = '0;
  logic gate, frame_start, busy;
  logic [SW-1:0] cur_slot;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  slot_gate_seq #(.N_SLOTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slot(req_slot),
    .gate(gate), .frame_start(frame_start), .cur_slot(cur_slot), .busy(busy)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pat_of(int s);
    return (s == 0) ? 0 : (1 << (s - 1));
  endfunction

  task automatic grab(output int pat, output int cs, output int bz, output int extra);
    do @(negedge clk); while (!frame_start);
    pat = 0; extra = 0;
    cs = int'(cur_slot);
    bz = int'(busy);
    for (int k = 0; k < N; k++) begin
      if (gate) pat |= (1 << k);
      if (k > 0 && frame_start) extra++;
      if (k < N - 1) @(negedge clk);
    end
  endtask

  task automatic issue(int s);
    do @(negedge clk); while (!frame_start);
    repeat (2) @(negedge clk);
    req_valid = 1'b1;
    req_slot  = SW'(s);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_frame(string req, int s, int bz_exp);
    int pat, cs, bz, extra;
    grab(pat, cs, bz, extra);
    check(req, pat, pat_of(s));
    check(req, cs, s);
    check(req, bz, bz_exp);
    check({req, " R1"}, extra, 0);
  endtask

  task automatic t_reset;
    check("R3 busy after reset", int'(busy), 0);
    expect_frame("R3 idle null frame", 0, 0);
    expect_frame("R3 idle null frame 2", 0, 0);
  endtask

  task automatic t_first;
    issue(2);
    check("R6 busy after accept", int'(busy), 1);
    expect_frame("R3 R5 first request no null", 2, 0);
  endtask

  task automatic t_immediate;
    issue(7);
    check("R6 busy after accept", int'(busy), 1);
    expect_frame("R4 immediate 2->7", 7, 0);
    expect_frame("R2 slot 7 repeats", 7, 0);
  endtask

  task automatic t_null;
    issue(2);
    expect_frame("R4 R6 null before 7->2", 0, 1);
    expect_frame("R4 dest after null 2", 2, 0);
    issue(5);
    expect_frame("R4 R6 null before 2->5", 0, 1);
    expect_frame("R4 dest after null 5", 5, 0);
  endtask

  task automatic t_tie;
    issue(1);
    expect_frame("R4 tie 5->1 immediate", 1, 0);
  endtask

  task automatic t_same;
    issue(1);
    check("R7 same slot busy", int'(busy), 0);
    expect_frame("R7 same slot unchanged", 1, 0);
  endtask

  task automatic t_bad;
    issue(0);
    check("R8 index 0 busy", int'(busy), 0);
    issue(8);
    check("R8 index 8 busy", int'(busy), 0);
    issue(15);
    check("R8 index 15 busy", int'(busy), 0);
    expect_frame("R8 pattern unchanged", 1, 0);
  endtask

  task automatic t_busy_ignore;
    issue(4);
    check("R6 busy after accept", int'(busy), 1);
    req_valid = 1'b1;
    req_slot  = SW'(6);
    @(negedge clk);
    req_valid = 1'b0;
    expect_frame("R9 R4 null before 1->4", 0, 1);
    expect_frame("R9 first request wins", 4, 0);
    expect_frame("R9 no late retune", 4, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first();
    t_immediate();
    t_null();
    t_tie();
    t_same();
    t_bad();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule